// File: doc/BRIEF.md
# Translation Table Maintenance Engine

This engine owns a table of I/O translation entries and carries out the commands that change or inspect it. Only one command runs at a time. A command names an operation, an I/O address, a 64-bit value and a page count. The engine then works through the affected pages one by one and reports a single final status, either success or parameter error. Get commands also return the entry they read.

There are four operations:
- **Put** stores one entry.
- **Get** returns one entry.
- **Fill** stores the same value in a run of consecutive pages.
- **List** reads a run of entries from an array in memory, one 64-bit word per page, over a simple read port. It stores them in consecutive pages.

Each entry that is stored produces a one-cycle invalidation notice. The notice describes the new mapping, so that a downstream translation cache can drop any stale copy. Reset returns every entry to zero, which means no access for every page.

Top module: `xlate_table_engine`

## Requirements
- R1: After reset every table entry reads as zero, and busy, doneValid, noteValid and memReqValid are all low.
- R2: The I/O address is first rounded down to a page boundary. The entry index is (rounded address minus BUS_OFFSET) shifted right by PAGE_SHIFT, with unsigned ADDR_W-bit wrap. Put (cmdOp=0) stores cmdValue at that index.
- R3: A step whose index is ENTRY_COUNT or more writes nothing, emits no notice, and ends the command with doneErr=1. This includes addresses below BUS_OFFSET.
- R4: Get (cmdOp=1) ends with doneErr=0 and doneData equal to the stored entry. An errored command always shows doneData=0, and so does a successful put, fill or list.
- R5: Fill (cmdOp=2) writes cmdValue to cmdCount consecutive pages. It advances one page per step and stops at the first out-of-range page with doneErr=1. Pages written before that point keep their new value.
- R6: A fill whose cmdCount exceeds ENTRY_COUNT ends with doneErr=1 and changes no entry.
- R7: List (cmdOp=3) reads element i at address base+8*i, where base is cmdValue[ADDR_W-1:0] with bits [1:0] cleared. memRspData holds the byte at the lowest address in bits [7:0]. The entry is big-endian, so that byte becomes entry bits [63:56]. Each element is written to successive pages.
- R8: A list command is rejected with doneErr=1 and no write if cmdCount exceeds MAX_LIST (512) or if cmdValue bits [11:2] are not all zero. Bits [1:0] are ignored.
- R9: Each entry write produces a one-cycle noteValid carrying:
  - noteIova: the page-aligned I/O address;
  - noteTarget: the entry with bits [PAGE_SHIFT-1:0] cleared;
  - noteMask: the value 2^PAGE_SHIFT-1;
  - notePerm: entry bits [1:0].
- R10: A fill or list with cmdCount=0 ends with doneErr=0 and writes nothing.
- R11: A command is accepted only when busy is low. Busy stays high from the cycle after acceptance through the cycle in which doneValid pulses for one cycle. Commands presented while busy is high are ignored.
- R12: A list command stops at the first out-of-range page with doneErr=1. Pages already written keep their new values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Command present; taken when busy is low |
| cmdOp | input | 2 | 0 put, 1 get, 2 fill, 3 list |
| cmdAddr | input | ADDR_W | I/O address of the first page |
| cmdValue | input | 64 | Entry value (put, fill) or list address (list) |
| cmdCount | input | CNT_W | Page count for fill and list |
| busy | output | 1 | Command in progress |
| doneValid | output | 1 | One-cycle final status strobe |
| doneErr | output | 1 | Parameter error when set |
| doneData | output | 64 | Entry read by a get, zero otherwise |
| memReqValid | output | 1 | One-cycle list-word read request |
| memReqAddr | output | ADDR_W | Byte address of the requested word |
| memRspValid | input | 1 | Read data present |
| memRspData | input | 64 | Read data, lowest address in bits [7:0] |
| noteValid | output | 1 | Invalidation notice strobe |
| noteIova | output | ADDR_W | Page-aligned I/O address of the written page |
| noteTarget | output | 64 | Entry with in-page bits cleared |
| noteMask | output | 64 | In-page offset mask |
| notePerm | output | 2 | Permission bits of the entry |

## Verification
The bound checker watches properties that must hold on every cycle:
- doneValid and memReqValid are one-cycle pulses;
- no notice or memory request appears while the engine is idle;
- acceptance raises busy;
- an error result never carries data;
- every notice has an aligned address and a target with no in-page bits set.

Other behaviours only the bench's scenarios can show. These are which page an address selects, the stopping point of fill and list runs, the rejection of bad counts and list addresses before any write, the byte order of list words, and that commands offered while busy leave the table untouched. The bench shows them by comparing every notice and every final status against a behavioural table model, and by reading pages back with get.

// File: rtl/xlt_pkg.sv
package xlt_pkg;
  typedef enum logic [1:0] {
    OP_PUT  = 2'd0,
    OP_GET  = 2'd1,
    OP_FILL = 2'd2,
    OP_LIST = 2'd3
  } op_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_FETCH,
    S_WAITM,
    S_WORK,
    S_DONE
  } state_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;        // capture a new command
    logic wrEntry;     // store entVal at current page, emit notice
    logic rdEntry;     // capture current page entry for a get
    logic latchFetch;  // take a list word from the read port
    logic advance;     // step to the next page and list element
  } strobe_t;
endpackage

// File: rtl/xlt_ctrl.sv
module xlt_ctrl
  import xlt_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int ENTRY_COUNT = 16,
  parameter int MAX_LIST    = 512,
  parameter int LIST_ALIGN  = 12
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  cmdValid,
  input  logic [1:0]            cmdOp,
  input  logic [CNT_W-1:0]      cmdCount,
  input  logic [LIST_ALIGN-1:2] listAlignBits,
  input  logic                  inRange,
  input  logic                  memRspValid,
  output strobe_t               stb,
  output logic                  busy,
  output logic                  doneValid,
  output logic                  doneErr,
  output logic                  memReqValid
);
  localparam logic [CNT_W-1:0] FILL_LIMIT = CNT_W'(ENTRY_COUNT);
  localparam logic [CNT_W-1:0] LIST_LIMIT = CNT_W'(MAX_LIST);

  state_e            state, stateN;
  op_e               opReg, opN;
  logic [CNT_W-1:0]  remain, remainN;
  logic              errFlag, errN;

  logic fillBad, listBad, zeroCnt;
  assign fillBad = cmdCount > FILL_LIMIT;
  assign listBad = (cmdCount > LIST_LIMIT) || (listAlignBits != '0);
  assign zeroCnt = (cmdCount == '0);

  always_comb begin
    stb     = '0;
    stateN  = state;
    opN     = opReg;
    remainN = remain;
    errN    = errFlag;
    unique case (state)
      S_IDLE: if (cmdValid) begin
        stb.load = 1'b1;
        opN      = op_e'(cmdOp);
        errN     = 1'b0;
        remainN  = cmdCount;
        unique case (op_e'(cmdOp))
          OP_PUT, OP_GET: begin
            remainN = CNT_W'(1);
            stateN  = S_WORK;
          end
          OP_FILL: begin
            if (fillBad) begin
              errN   = 1'b1;
              stateN = S_DONE;
            end else stateN = zeroCnt ? S_DONE : S_WORK;
          end
          default: begin
            if (listBad) begin
              errN   = 1'b1;
              stateN = S_DONE;
            end else stateN = zeroCnt ? S_DONE : S_FETCH;
          end
        endcase
      end
      S_FETCH: stateN = S_WAITM;
      S_WAITM: if (memRspValid) begin
        stb.latchFetch = 1'b1;
        stateN         = S_WORK;
      end
      S_WORK: begin
        if (!inRange) begin
          errN   = 1'b1;
          stateN = S_DONE;
        end else begin
          if (opReg == OP_GET) stb.rdEntry = 1'b1;
          else                 stb.wrEntry = 1'b1;
          if (remain == CNT_W'(1)) stateN = S_DONE;
          else begin
            remainN     = remain - CNT_W'(1);
            stb.advance = 1'b1;
            stateN      = (opReg == OP_LIST) ? S_FETCH : S_WORK;
          end
        end
      end
      default: stateN = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_IDLE;
      opReg   <= OP_PUT;
      remain  <= '0;
      errFlag <= 1'b0;
    end else begin
      state   <= stateN;
      opReg   <= opN;
      remain  <= remainN;
      errFlag <= errN;
    end
  end

  assign busy        = (state != S_IDLE);
  assign doneValid   = (state == S_DONE);
  assign doneErr     = (state == S_DONE) && errFlag;
  assign memReqValid = (state == S_FETCH);
endmodule

// File: rtl/xlt_dpath.sv
module xlt_dpath
  import xlt_pkg::*;
#(
  parameter int          ADDR_W      = 32,
  parameter int          ENT_W       = 64,
  parameter int          ENTRY_COUNT = 16,
  parameter int          PAGE_SHIFT  = 12,
  parameter logic [31:0] BUS_OFFSET  = 32'h0010_0000
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic [ENT_W-1:0]  cmdValue,
  input  logic [ENT_W-1:0]  memRspData,
  output logic              inRange,
  output logic [ENT_W-1:0]  resData,
  output logic [ADDR_W-1:0] memReqAddr,
  output logic              noteValid,
  output logic [ADDR_W-1:0] noteIova,
  output logic [ENT_W-1:0]  noteTarget,
  output logic [ENT_W-1:0]  noteMask,
  output logic [1:0]        notePerm
);
  localparam int IDX_W  = (ENTRY_COUNT > 1) ? $clog2(ENTRY_COUNT) : 1;
  localparam int NBYTES = ENT_W / 8;
  localparam logic [ADDR_W-1:0] PAGE_BYTES = ADDR_W'(1) << PAGE_SHIFT;
  localparam logic [ADDR_W-1:0] ADDR_PMASK = ~(PAGE_BYTES - ADDR_W'(1));
  localparam logic [ENT_W-1:0]  ENT_LOW    = (ENT_W'(1) << PAGE_SHIFT) - ENT_W'(1);
  localparam logic [ADDR_W-1:0] WORD_BYTES = ADDR_W'(NBYTES);

  logic [ENT_W-1:0]  entryMem [ENTRY_COUNT];
  logic [ADDR_W-1:0] curAddr, listPtr, pageNum;
  logic [ENT_W-1:0]  entVal, swapped;
  logic [IDX_W-1:0]  idx;

  // page number relative to the bus window (wraps below the offset)
  assign pageNum = (curAddr - ADDR_W'(BUS_OFFSET)) >> PAGE_SHIFT;
  assign inRange = pageNum < ADDR_W'(ENTRY_COUNT);
  assign idx     = pageNum[IDX_W-1:0];

  // list words are big-endian: lowest-address byte is most significant
  for (genvar k = 0; k < NBYTES; k++) begin : g_swap
    assign swapped[ENT_W-1-8*k -: 8] = memRspData[8*k +: 8];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < ENTRY_COUNT; i++) entryMem[i] <= '0;
      curAddr    <= '0;
      listPtr    <= '0;
      entVal     <= '0;
      resData    <= '0;
      noteValid  <= 1'b0;
      noteIova   <= '0;
      noteTarget <= '0;
      notePerm   <= '0;
    end else begin
      noteValid <= 1'b0;
      if (stb.load) begin
        curAddr <= cmdAddr & ADDR_PMASK;
        entVal  <= cmdValue;
        listPtr <= cmdValue[ADDR_W-1:0] & ~ADDR_W'(3);
        resData <= '0;
      end
      if (stb.latchFetch) entVal <= swapped;
      if (stb.wrEntry) begin
        entryMem[idx] <= entVal;
        noteValid     <= 1'b1;
        noteIova      <= curAddr;
        noteTarget    <= entVal & ~ENT_LOW;
        notePerm      <= entVal[1:0];
      end
      if (stb.rdEntry) resData <= entryMem[idx];
      if (stb.advance) begin
        curAddr <= curAddr + PAGE_BYTES;
        listPtr <= listPtr + WORD_BYTES;
      end
    end
  end

  assign memReqAddr = listPtr;
  assign noteMask   = ENT_LOW;
endmodule

// File: rtl/xlate_table_engine.sv
module xlate_table_engine
  import xlt_pkg::*;
#(
  parameter int          ADDR_W      = 32,
  parameter int          ENTRY_COUNT = 16,
  parameter int          PAGE_SHIFT  = 12,
  parameter logic [31:0] BUS_OFFSET  = 32'h0010_0000,
  parameter int          CNT_W       = 16,
  parameter int          MAX_LIST    = 512,
  parameter int          LIST_ALIGN  = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic [1:0]        cmdOp,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic [63:0]       cmdValue,
  input  logic [CNT_W-1:0]  cmdCount,
  output logic              busy,
  output logic              doneValid,
  output logic              doneErr,
  output logic [63:0]       doneData,
  output logic              memReqValid,
  output logic [ADDR_W-1:0] memReqAddr,
  input  logic              memRspValid,
  input  logic [63:0]       memRspData,
  output logic              noteValid,
  output logic [ADDR_W-1:0] noteIova,
  output logic [63:0]       noteTarget,
  output logic [63:0]       noteMask,
  output logic [1:0]        notePerm
);
  strobe_t    stb;
  logic       inRange;
  logic [63:0] resData;

  xlt_ctrl #(
    .CNT_W(CNT_W), .ENTRY_COUNT(ENTRY_COUNT),
    .MAX_LIST(MAX_LIST), .LIST_ALIGN(LIST_ALIGN)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .cmdCount(cmdCount), .listAlignBits(cmdValue[LIST_ALIGN-1:2]),
    .inRange(inRange), .memRspValid(memRspValid), .stb(stb),
    .busy(busy), .doneValid(doneValid), .doneErr(doneErr),
    .memReqValid(memReqValid)
  );

  xlt_dpath #(
    .ADDR_W(ADDR_W), .ENT_W(64), .ENTRY_COUNT(ENTRY_COUNT),
    .PAGE_SHIFT(PAGE_SHIFT), .BUS_OFFSET(BUS_OFFSET)
  ) u_dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .cmdAddr(cmdAddr),
    .cmdValue(cmdValue), .memRspData(memRspData), .inRange(inRange),
    .resData(resData), .memReqAddr(memReqAddr), .noteValid(noteValid),
    .noteIova(noteIova), .noteTarget(noteTarget), .noteMask(noteMask),
    .notePerm(notePerm)
  );

  assign doneData = resData;
endmodule

// File: rtl/xlt_checker.sv
module xlt_checker #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              cmdValid,
  input logic              busy,
  input logic              doneValid,
  input logic              doneErr,
  input logic [63:0]       doneData,
  input logic              memReqValid,
  input logic [ADDR_W-1:0] memReqAddr,
  input logic              noteValid,
  input logic [ADDR_W-1:0] noteIova,
  input logic [63:0]       noteTarget,
  input logic [63:0]       noteMask
);
  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |=> !doneValid);
  p_done_busy_r11: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |-> busy);
  p_accept_busy_r11: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && !busy) |=> busy);
  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!noteValid && !memReqValid));
  p_err_nodata_r4: assert property (@(posedge clk) disable iff (!rstN)
    (doneValid && doneErr) |-> (doneData == 64'd0));
  p_note_aligned_r9: assert property (@(posedge clk) disable iff (!rstN)
    noteValid |-> (((noteTarget & noteMask) == 64'd0) &&
                   ((noteIova & noteMask[ADDR_W-1:0]) == '0)));
  p_req_pulse_r7: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |=> !memReqValid);
  p_req_word_r7: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |-> ((memReqAddr & ADDR_W'(3)) == '0));
endmodule

bind xlate_table_engine xlt_checker #(.ADDR_W(ADDR_W)) u_xlt_checker (
  .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .busy(busy),
  .doneValid(doneValid), .doneErr(doneErr), .doneData(doneData),
  .memReqValid(memReqValid), .memReqAddr(memReqAddr),
  .noteValid(noteValid), .noteIova(noteIova), .noteTarget(noteTarget),
  .noteMask(noteMask)
);

// File: tb/test_xlate_table_engine.sv
`timescale 1ns/1ps
module test_xlate_table_engine;
  localparam int          NENT = 16;
  localparam logic [31:0] OFF  = 32'h0010_0000;
  localparam logic [31:0] PG   = 32'h0000_1000;

  typedef struct {
    logic [31:0] iova;
    logic [63:0] tgt;
    logic [1:0]  perm;
  } note_t;

  logic        clk = 0, rstN = 0;
  logic        cmdValid = 0;
  logic [1:0]  cmdOp = 0;
  logic [31:0] cmdAddr = 0;
  logic [63:0] cmdValue = 0;
  logic [15:0] cmdCount = 0;
  logic        busy, doneValid, doneErr, memReqValid, noteValid;
  logic [63:0] doneData, noteTarget, noteMask;
  logic [31:0] memReqAddr, noteIova;
  logic        memRspValid = 0;
  logic [63:0] memRspData = 0;
  logic [1:0]  notePerm;

  int total = 0, bad = 0;
  logic [63:0] refTab [NENT];
  note_t expQ[$];
  logic  pend = 0;
  logic [31:0] pendAddr = 0;

  xlate_table_engine i_xlate_table_engine (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .cmdAddr(cmdAddr), .cmdValue(cmdValue), .cmdCount(cmdCount),
    .busy(busy), .doneValid(doneValid), .doneErr(doneErr),
    .doneData(doneData), .memReqValid(memReqValid), .memReqAddr(memReqAddr),
    .memRspValid(memRspValid), .memRspData(memRspData),
    .noteValid(noteValid), .noteIova(noteIova), .noteTarget(noteTarget),
    .noteMask(noteMask), .notePerm(notePerm)
  );

  always #10 clk = ~clk;

  // list word stored big-endian at byte address a
  function automatic logic [63:0] listWord(input logic [31:0] a);
    return {a ^ 32'h5A00_0000, 20'h0, a[11:0] | {10'h0, a[4:3]}};
  endfunction

  // memory: answers one cycle after a request is seen
  always @(negedge clk) begin
    logic [63:0] w;
    w = listWord(pendAddr);
    memRspValid = pend;
    memRspData  = {<<8{w}};
    pend     = memReqValid;
    pendAddr = memReqAddr;
  end

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // behavioural table model
  task automatic predict(input logic [1:0] op, input logic [31:0] addr,
                         input logic [63:0] val, input int cnt,
                         output bit err, output logic [63:0] data);
    logic [31:0] al, base, a, pg;
    logic [63:0] e;
    int n;
    note_t nt;
    err = 0; data = 0;
    al = addr & ~(PG - 1);
    base = val[31:0] & ~32'd3;
    n = (op < 2) ? 1 : cnt;
    if (op == 2 && cnt > NENT) begin err = 1; n = 0; end
    if (op == 3 && (cnt > 512 || val[11:2] != 0)) begin err = 1; n = 0; end
    for (int i = 0; i < n; i++) begin
      a  = al + PG * i;
      pg = (a - OFF) >> 12;
      if (pg >= NENT) begin err = 1; break; end
      e = (op == 3) ? listWord(base + 8 * i) : val;
      if (op == 1) data = refTab[pg];
      else begin
        refTab[pg] = e;
        nt.iova = a; nt.tgt = e & ~64'hFFF; nt.perm = e[1:0];
        expQ.push_back(nt);
      end
    end
  endtask

  task automatic runCmd(input logic [1:0] op, input logic [31:0] addr,
                        input logic [63:0] val, input int cnt,
                        input string tag, input bit intrude);
    bit eErr;
    logic [63:0] eData;
    int w;
    note_t nt;
    predict(op, addr, val, cnt, eErr, eData);
    @(negedge clk);
    cmdValid = 1; cmdOp = op; cmdAddr = addr; cmdValue = val; cmdCount = 16'(cnt);
    @(negedge clk);
    cmdValid = 0;
    w = 0;
    forever begin
      if (noteValid) begin
        if (expQ.size() == 0) check(0, tag, "unexpected notice", 128'(noteIova), 0);
        else begin
          nt = expQ.pop_front();
          check({noteIova, noteTarget, notePerm, noteMask} ==
                {nt.iova, nt.tgt, nt.perm, 64'hFFF}, tag, "notice",
                {noteIova, noteTarget, notePerm}, {nt.iova, nt.tgt, nt.perm});
        end
      end
      if (!busy) check(0, tag, "busy low before done", 0, 1);
      if (doneValid || w > 3000) break;
      if (intrude) begin
        cmdValid = 1; cmdOp = 2'd0; cmdAddr = OFF + 7 * PG; cmdValue = 64'hDEAD_0003;
      end
      @(negedge clk);
      w++;
    end
    cmdValid = 0;
    check(doneValid && doneErr == eErr && doneData == eData, tag, "final status",
          {63'(doneValid), doneErr, doneData}, {64'd1, eErr, eData});
    check(expQ.size() == 0, tag, "missing notices", expQ.size(), 0);
    expQ.delete();
  endtask

  task automatic doReset();
    rstN = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1;
    for (int i = 0; i < NENT; i++) refTab[i] = 0;
  endtask

  initial begin
    doReset();
    check({busy, doneValid, noteValid, memReqValid} == 4'b0, "R1", "reset outputs",
          {busy, doneValid, noteValid, memReqValid}, 0);
    runCmd(1, OFF, 0, 0, "R1", 0);
    runCmd(1, OFF + 15 * PG, 0, 0, "R1", 0);
    // single put with in-page offset bits, then readback
    runCmd(0, OFF + 3 * PG + 32'h123, 64'h0000_0012_3456_7ABF, 0, "R2", 0);
    runCmd(1, OFF + 3 * PG + 32'hFFF, 0, 0, "R4", 0);
    runCmd(0, OFF + 5 * PG, 64'h0000_0000_0ABC_D001, 0, "R9", 0);
    // out of range puts and get
    runCmd(0, OFF + 16 * PG, 64'h1111, 0, "R3", 0);
    runCmd(0, OFF - PG, 64'h2222, 0, "R3", 0);
    runCmd(1, OFF + 20 * PG, 0, 0, "R4", 0);
    // fills
    runCmd(2, OFF + 4 * PG + 32'h10, 64'h0000_0007_7000_0002, 4, "R5", 0);
    runCmd(2, OFF + 14 * PG, 64'h0000_0009_9000_0003, 5, "R5", 0);
    runCmd(1, OFF + 15 * PG, 0, 0, "R5", 0);
    runCmd(2, OFF, 64'h3333, 17, "R6", 0);
    runCmd(1, OFF, 0, 0, "R6", 0);
    runCmd(2, OFF, 64'h4444, 0, "R10", 0);
    runCmd(3, OFF, 64'h8000_2000, 0, "R10", 0);
    runCmd(1, OFF, 0, 0, "R10", 0);
    // list writes
    runCmd(3, OFF + 8 * PG, 64'h8000_2000, 3, "R7", 0);
    runCmd(1, OFF + 10 * PG, 0, 0, "R7", 0);
    runCmd(3, OFF + 11 * PG, 64'h8000_3003, 2, "R8", 0);
    runCmd(3, OFF + 2 * PG, 64'h8000_2010, 1, "R8", 0);
    runCmd(3, OFF + 2 * PG, 64'h8000_2000, 513, "R8", 0);
    runCmd(1, OFF + 2 * PG, 0, 0, "R8", 0);
    runCmd(3, OFF + 13 * PG, 64'h8000_4000, 5, "R12", 0);
    runCmd(1, OFF + 13 * PG, 0, 0, "R12", 0);
    // commands offered while busy are dropped
    runCmd(2, OFF + 4 * PG, 64'h0000_0005_5000_0001, 3, "R11", 1);
    runCmd(1, OFF + 7 * PG, 0, 0, "R11", 0);
    // reset clears previously written entries
    doReset();
    runCmd(1, OFF + 3 * PG, 0, 0, "R1", 0);
    runCmd(1, OFF + 9 * PG, 0, 0, "R1", 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog R11 actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule